// File: doc/BRIEF.md
# Dual-Clock FIFO with Read Rewind

This block is a first-in first-out buffer whose write port and read port run on unrelated clocks. Words go in on `wclk` and come out on `rclk`. The read and write positions cross between the two clock domains as Gray code through synchronizer chains. All status flags are computed in the domain of the port they guard. The buffer has two output behaviours, chosen while master reset is held. In standard mode a read request loads the next word into the output register. In fall-through mode the oldest word appears on the output without any request, and a read request moves on to the next word.

Programmable thresholds drive an almost-full flag and an almost-empty flag, both active low, and a half-full flag, also active low. The two threshold values arrive on input ports from a separate register block. A partial reset empties the buffer but keeps the mode chosen at the last master reset. A rewind request, sampled on the read clock, sends the read position back to the first storage slot. The data written since the last reset can then be read again, while the write position is left alone.

Top module: `rt_fifo`

## Requirements
- R1: While `mrst_n` is low, `fwft_sel` is sampled (0 = standard, 1 = fall-through) and both positions and `dout` are cleared to zero. The mode then holds until the next master reset.
- R2: A low `prst_n` clears both positions and `dout` to zero and leaves the mode unchanged, whatever `fwft_sel` is during it.
- R3: In standard mode `full_ir` is 1 exactly when DEPTH words are stored. A write while full is dropped and leaves the stored data intact.
- R4: In standard mode, `ren` with words stored puts the oldest word on `dout` one `rclk` edge later, in write order. `ren` while empty leaves `dout` unchanged.
- R5: In standard mode `empty_or` is 1 exactly when no words are stored.
- R6: In fall-through mode the oldest word sits on `dout` with `empty_or` = 1 without any `ren`, and `ren` advances to the next word. `full_ir` = 1 means a write will be accepted. The buffer holds DEPTH+1 words: DEPTH in memory plus one in the output register.
- R7: `rt` high at an `rclk` edge sets the read position to zero, so the next reads return the words in the order written since the last reset. The write position is not affected. This holds provided no more than DEPTH words have been written since that reset.
- R8: In the `rclk` cycle after a rewind edge, `empty_or` shows no data: 1 in standard mode, 0 in fall-through mode.
- R9: `paf_n` is 0 exactly when the memory word count exceeds DEPTH minus `af_off`, with `af_off` between 0 and DEPTH.
- R10: `pae_n` is 0 exactly when the memory word count is below `ae_off`. In fall-through mode the memory word count excludes the word in the output register.
- R11: `hf_n` is 0 exactly when the memory word count is above DEPTH/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; clears data and samples the mode |
| prst_n | input | 1 | Partial reset, active low; clears data and keeps the mode |
| fwft_sel | input | 1 | Mode choice sampled during master reset (1 = fall-through) |
| wen | input | 1 | Write request, sampled on `wclk` |
| din | input | DW | Write data |
| ren | input | 1 | Read request, sampled on `rclk` |
| rt | input | 1 | Rewind request, sampled on `rclk` |
| af_off | input | AW+1 | Almost-full offset |
| ae_off | input | AW+1 | Almost-empty offset |
| dout | output | DW | Output data register |
| full_ir | output | 1 | Full (standard) or input-ready (fall-through) |
| empty_or | output | 1 | Empty (standard) or output-ready (fall-through) |
| paf_n | output | 1 | Almost-full, active low |
| pae_n | output | 1 | Almost-empty, active low |
| hf_n | output | 1 | Half-full, active low |

## Verification
The assertions watch on every cycle that a write into a full standard-mode buffer does not move the write position. They check that a read of an empty standard-mode buffer leaves `dout` alone, and that a held fall-through word stays put until it is consumed. They also check that a rewind zeroes the read position and shows no-data on the following cycle. The bench scenarios show what only a sequence can: data order across fills, overflows and drains. They cover the exact thresholds of the three level flags after the positions have crossed domains, and the replay of words after a rewind. They also show that the mode survives a partial reset but not a master reset.

// File: rtl/rt_fifo_pkg.sv
package rt_fifo_pkg;
   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } fifo_mode_e;
endpackage

// File: rtl/rt_fifo_sync.sv
// Multi-stage synchronizer; with d tied high it doubles as a reset release chain.
module rt_fifo_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rt_fifo_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_w
         $error("rt_fifo_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/rt_fifo_wside.sv
module rt_fifo_wside
   import rt_fifo_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  fifo_mode_e  mode,
   input  logic        wen,
   input  logic [AW:0] rgray_s,
   input  logic [AW:0] af_off,
   output logic        we,
   output logic [AW-1:0] waddr,
   output logic [AW:0] wbin,
   output logic [AW:0] wgray,
   output logic        full_ir,
   output logic        paf_n,
   output logic        hf_n
);
   localparam logic [AW:0] DEPTH = {1'b1, {AW{1'b0}}};
   localparam logic [AW:0] HALF  = DEPTH >> 1;

   logic [AW:0] rbin_s, nxt, cnt;
   logic        full;

   // Gray to binary: each bit is the parity of itself and all bits above.
   generate
      for (genvar i = 0; i <= AW; i++) begin : g_g2b
         assign rbin_s[i] = ^rgray_s[AW:i];
      end
   endgenerate

   assign full  = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
   assign we    = wen & ~full;
   assign nxt   = wbin + (AW+1)'(1);
   assign waddr = wbin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (we) begin
         wbin  <= nxt;
         wgray <= nxt ^ (nxt >> 1);
      end
   end

   assign cnt     = wbin - rbin_s;
   assign paf_n   = ~(cnt > (DEPTH - af_off));
   assign hf_n    = ~(cnt > HALF);
   assign full_ir = (mode == MODE_FWFT) ? ~full : full;
endmodule

// File: rtl/rt_fifo_rside.sv
module rt_fifo_rside
   import rt_fifo_pkg::*;
#(
   parameter int AW = 4,
   parameter int DW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  fifo_mode_e    mode,
   input  logic          ren,
   input  logic          rt,
   input  logic [AW:0]   wgray_s,
   input  logic [AW:0]   ae_off,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rbin,
   output logic [AW:0]   rgray,
   output logic [DW-1:0] dout,
   output logic          empty_or,
   output logic          pae_n
);
   logic [AW:0] wbin_s, nxt, cnt;
   logic        mem_empty, rd, ov, rt_q;

   generate
      for (genvar i = 0; i <= AW; i++) begin : g_g2b
         assign wbin_s[i] = ^wgray_s[AW:i];
      end
   endgenerate

   assign mem_empty = (rgray == wgray_s);
   assign nxt       = rbin + (AW+1)'(1);
   assign raddr     = rbin[AW-1:0];

   // Standard mode pulls on request; fall-through refills the output register
   // whenever it is empty or being consumed. Rewind blocks both for two edges.
   always_comb begin
      if (mode == MODE_FWFT) rd = ~mem_empty & ~rt & ~rt_q & (~ov | ren);
      else                   rd = ~mem_empty & ~rt & ~rt_q & ren;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
         dout  <= '0;
         ov    <= 1'b0;
         rt_q  <= 1'b0;
      end else begin
         rt_q <= rt;
         if (rt) begin
            rbin  <= '0;
            rgray <= '0;
            ov    <= 1'b0;
         end else begin
            if (rd) begin
               dout  <= rdata;
               rbin  <= nxt;
               rgray <= nxt ^ (nxt >> 1);
            end
            ov <= (mode == MODE_FWFT) & (rd | (ov & ~ren));
         end
      end
   end

   assign empty_or = (mode == MODE_FWFT) ? (ov & ~rt_q) : (mem_empty | rt_q);
   assign cnt      = wbin_s - rbin;
   assign pae_n    = ~(cnt < ae_off);
endmodule

// File: rtl/rt_fifo.sv
module rt_fifo
   import rt_fifo_pkg::*;
#(
   parameter int DW          = 9,
   parameter int AW          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          fwft_sel,
   input  logic          wen,
   input  logic [DW-1:0] din,
   input  logic          ren,
   input  logic          rt,
   input  logic [AW:0]   af_off,
   input  logic [AW:0]   ae_off,
   output logic [DW-1:0] dout,
   output logic          full_ir,
   output logic          empty_or,
   output logic          paf_n,
   output logic          pae_n,
   output logic          hf_n
);
   localparam int DEPTH = 1 << AW;

   generate
      if (DW < 1) begin : g_bad_dw
         $error("rt_fifo: DW must be at least 1");
      end
      if (AW < 2 || AW > 12) begin : g_bad_aw
         $error("rt_fifo: AW must lie in 2..12");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rt_fifo: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic          arst_n, w_rst_n, r_rst_n, we;
   fifo_mode_e    mode_w, mode_r;
   logic [AW-1:0] waddr, raddr;
   logic [AW:0]   wbin, wgray, rbin, rgray, wgray_s, rgray_s;
   logic [DW-1:0] rdata;
   logic [DW-1:0] mem [DEPTH];

   assign arst_n = mrst_n & prst_n;

   rt_fifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wrst (
      .clk(wclk), .rst_n(arst_n), .d(1'b1), .q(w_rst_n));
   rt_fifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rrst (
      .clk(rclk), .rst_n(arst_n), .d(1'b1), .q(r_rst_n));

   // Mode is captured only during master reset, so partial reset keeps it.
   always_ff @(posedge wclk) if (!mrst_n) mode_w <= fifo_mode_e'(fwft_sel);
   always_ff @(posedge rclk) if (!mrst_n) mode_r <= fifo_mode_e'(fwft_sel);

   rt_fifo_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(w_rst_n), .d(rgray), .q(rgray_s));
   rt_fifo_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(r_rst_n), .d(wgray), .q(wgray_s));

   rt_fifo_wside #(.AW(AW)) u_wside (
      .clk(wclk), .rst_n(w_rst_n), .mode(mode_w), .wen(wen),
      .rgray_s(rgray_s), .af_off(af_off), .we(we), .waddr(waddr),
      .wbin(wbin), .wgray(wgray), .full_ir(full_ir), .paf_n(paf_n), .hf_n(hf_n));

   always_ff @(posedge wclk) if (we) mem[waddr] <= din;
   assign rdata = mem[raddr];

   rt_fifo_rside #(.AW(AW), .DW(DW)) u_rside (
      .clk(rclk), .rst_n(r_rst_n), .mode(mode_r), .ren(ren), .rt(rt),
      .wgray_s(wgray_s), .ae_off(ae_off), .rdata(rdata), .raddr(raddr),
      .rbin(rbin), .rgray(rgray), .dout(dout), .empty_or(empty_or), .pae_n(pae_n));
endmodule

// File: rtl/rt_fifo_chk.sv
module rt_fifo_chk #(
   parameter int AW = 4,
   parameter int DW = 9
) (
   input logic          wclk,
   input logic          rclk,
   input logic          w_rst_n,
   input logic          r_rst_n,
   input logic          mode_w,
   input logic          mode_r,
   input logic          wen,
   input logic          ren,
   input logic          rt,
   input logic          full_ir,
   input logic          empty_or,
   input logic [AW:0]   wbin,
   input logic [AW:0]   rbin,
   input logic [DW-1:0] dout
);
   // R3: a write into a full standard-mode buffer must not move the write position
   p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!w_rst_n)
      (!mode_w && full_ir && wen) |=> (wbin == $past(wbin)));

   // R4: a read request on an empty standard-mode buffer leaves the output alone
   p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!r_rst_n)
      (!mode_r && empty_or && ren) |=> $stable(dout));

   // R6: a presented fall-through word stays until consumed or rewound
   p_fwft_hold_r6: assert property (@(posedge rclk) disable iff (!r_rst_n)
      (mode_r && empty_or && !ren && !rt) |=> ($stable(dout) && empty_or));

   // R7: rewind zeroes the read position
   p_rewind_zero_r7: assert property (@(posedge rclk) disable iff (!r_rst_n)
      rt |=> (rbin == '0));

   // R8: the cycle after a rewind shows no data
   p_rewind_flag_r8: assert property (@(posedge rclk) disable iff (!r_rst_n)
      rt |=> (empty_or == !mode_r));
endmodule

bind rt_fifo rt_fifo_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_rt_fifo.sv
module tb_rt_fifo;
   localparam int DW = 9;
   localparam int AW = 4;
   localparam int DEPTH = 1 << AW;
   localparam int AF = 2;
   localparam int AE = 4;

   logic wclk = 0, rclk = 0;
   logic mrst_n = 0, prst_n = 1, fwft_sel = 0;
   logic wen = 0, ren = 0, rt = 0;
   logic [DW-1:0] din = '0;
   logic [AW:0] af_off = AF[AW:0], ae_off = AE[AW:0];
   logic [DW-1:0] dout;
   logic full_ir, empty_or, paf_n, pae_n, hf_n;

   always #2.5 wclk = ~wclk;
   always #3.5 rclk = ~rclk;

   rt_fifo #(.DW(DW), .AW(AW), .SYNC_STAGES(2)) dut (
      .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
      .fwft_sel(fwft_sel), .wen(wen), .din(din), .ren(ren), .rt(rt),
      .af_off(af_off), .ae_off(ae_off), .dout(dout), .full_ir(full_ir),
      .empty_or(empty_or), .paf_n(paf_n), .pae_n(pae_n), .hf_n(hf_n));

   int n_run = 0, n_fail = 0;
   bit done = 0;
   bit mode_m = 0;
   int q_m[$];
   int hist[$];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (10) @(posedge wclk);
      repeat (10) @(posedge rclk);
      @(negedge rclk);
   endtask

   function automatic int mem_cnt();
      int s = q_m.size();
      if (mode_m && s > 0) return s - 1;
      return s;
   endfunction

   task automatic check_flags(string tag);
      int c = mem_cnt();
      int s = q_m.size();
      if (mode_m) begin
         chk({"R6 input-ready ", tag}, full_ir, c != DEPTH);
         chk({"R6 output-ready ", tag}, empty_or, s > 0);
      end else begin
         chk({"R3 full ", tag}, full_ir, s == DEPTH);
         chk({"R5 empty ", tag}, empty_or, s == 0);
      end
      chk({"R9 almost-full ", tag}, paf_n, !(c > DEPTH - AF));
      chk({"R10 almost-empty ", tag}, pae_n, !(c < AE));
      chk({"R11 half-full ", tag}, hf_n, !(c > DEPTH / 2));
   endtask

   task automatic mreset(bit sel);
      @(negedge wclk);
      mrst_n = 0; fwft_sel = sel;
      repeat (4) @(posedge wclk);
      repeat (4) @(posedge rclk);
      @(negedge wclk);
      mrst_n = 1; fwft_sel = 0;
      mode_m = sel; q_m.delete(); hist.delete();
      settle();
   endtask

   task automatic preset(bit sel_during);
      @(negedge wclk);
      prst_n = 0; fwft_sel = sel_during;
      repeat (4) @(posedge wclk);
      repeat (4) @(posedge rclk);
      @(negedge wclk);
      prst_n = 1; fwft_sel = 0;
      q_m.delete(); hist.delete();
      settle();
   endtask

   task automatic write_burst(int n, int base);
      for (int i = 0; i < n; i++) begin
         @(negedge wclk);
         wen = 1; din = DW'(base + i);
         if (q_m.size() < DEPTH + (mode_m ? 1 : 0)) begin
            q_m.push_back(base + i);
            hist.push_back(base + i);
         end
      end
      @(negedge wclk);
      wen = 0;
   endtask

   task automatic read_std(string req);
      logic [DW-1:0] prev = dout;
      int exp;
      @(negedge rclk); ren = 1;
      @(negedge rclk); ren = 0;
      if (q_m.size() > 0) exp = q_m.pop_front();
      else exp = int'(prev);
      chk({req, " read data"}, dout, exp);
   endtask

   task automatic read_fwft(string req);
      chk({req, " word presented"}, empty_or, 1);
      chk({req, " presented data"}, dout, q_m[0]);
      @(negedge rclk); ren = 1;
      @(negedge rclk); ren = 0;
      void'(q_m.pop_front());
   endtask

   initial begin
      #600us;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: master reset into standard mode
      mreset(0);
      chk("R1 dout after reset", dout, 0);
      check_flags("after reset");

      // R4: read of empty buffer leaves dout
      read_std("R4 empty");
      chk("R5 still empty", empty_or, 1);

      // R4: small transfer in order
      write_burst(3, 'h101);
      settle();
      check_flags("three words");
      for (int i = 0; i < 3; i++) read_std("R4");
      settle();
      check_flags("drained");

      // R9 R10 R11 R3: flag thresholds word by word up to full
      for (int k = 0; k < DEPTH; k++) begin
         write_burst(1, 'h20 + k);
         settle();
         check_flags("fill step");
      end
      write_burst(2, 'h1F0);           // R3: dropped
      settle();
      check_flags("after overflow");
      for (int i = 0; i < DEPTH; i++) read_std("R3 R4 drain");
      settle();
      check_flags("after drain");

      // R7 R8: rewind in standard mode
      mreset(0);
      write_burst(5, 'h40);
      settle();
      read_std("R4 pre-rewind");
      read_std("R4 pre-rewind");
      @(negedge rclk); rt = 1;
      @(negedge rclk); rt = 0;
      chk("R8 empty after rewind", empty_or, 1);
      q_m = hist;
      settle();
      check_flags("after rewind");
      for (int i = 0; i < 5; i++) read_std("R7 replay");
      write_burst(1, 'h77);
      settle();
      read_std("R7 write position kept");

      // R6: fall-through mode
      mreset(1);
      chk("R1 dout after fwft reset", dout, 0);
      check_flags("fwft empty");
      write_burst(1, 'h150);
      settle();
      chk("R6 fall-through data", dout, 'h150);
      check_flags("fwft one");
      write_burst(DEPTH, 'h160);
      settle();
      check_flags("fwft full");
      write_burst(1, 'h1FF);           // dropped
      settle();
      check_flags("fwft after overflow");
      for (int i = 0; i < DEPTH + 1; i++) read_fwft("R6");
      settle();
      check_flags("fwft drained");

      // R2: partial reset keeps fall-through despite fwft_sel low
      write_burst(2, 'h90);
      settle();
      preset(0);
      chk("R2 dout cleared", dout, 0);
      chk("R2 output-ready cleared", empty_or, 0);
      write_burst(3, 'h1A0);
      settle();
      chk("R2 mode kept data", dout, 'h1A0);
      chk("R2 mode kept ready", empty_or, 1);

      // R7 R8: rewind in fall-through mode
      read_fwft("R6 pre-rewind");
      @(negedge rclk); rt = 1;
      @(negedge rclk); rt = 0;
      chk("R8 not ready after rewind", empty_or, 0);
      q_m = hist;
      settle();
      for (int i = 0; i < 3; i++) read_fwft("R7 fwft replay");

      // R1: master reset returns to standard mode
      mreset(0);
      write_burst(1, 'h55);
      settle();
      chk("R1 no fall-through in standard", dout, 0);
      chk("R5 not empty", empty_or, 0);
      read_std("R1 R4 standard again");

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule